// File: doc/BRIEF.md
# Window Watchdog with Strapped Period Selection

This block supervises a host processor. The host must write a refresh strobe once in every watchdog period, and only in the second part of that period. Each period is split into a closed half and an open half. A refresh in the open half starts a new period. Two things raise a one-cycle reset request and start a new period: a refresh in the closed half, or a period that ends with no refresh. Time is measured by counting pulses on a tick input that runs at 1 ms per tick.

A two-bit configuration strap picks the setup. It can turn supervision off completely. It can select a fixed default period of 150 ticks. It can select a period taken from a binary period code. The strap and the code are captured once, on the first clock edge after reset is released. Later changes to either input are ignored until the next reset.

The controller is a four-state machine:
- `ST_INIT` captures the configuration and clears the counter.
- `ST_IDLE` is the permanent state when supervision is off.
- `ST_CLOSED` is the first half of a period.
- `ST_OPEN` is the second half of a period.

The transitions are:
- init-to-idle, taken when the strap selects disabled.
- init-to-closed, taken for both enabled setups.
- closed-to-open, taken on the tick that completes the closed half.
- closed-self-restart, taken on an early refresh, with a fault.
- open-to-closed-refresh, taken on a good refresh.
- open-to-closed-timeout, taken on the tick that completes the period, with a fault.

Top module: `win_wdog`

## Requirements
- R1: The strap `cfg_strap` is decoded as follows: 2'b00 means disabled, 2'b01 means the default period, and 2'b10 or 2'b11 mean the programmed period. The strap and `period_code` are captured on the first rising clock edge after `rst_n` goes high.
- R2: Any change of `cfg_strap` or `period_code` after that capture edge has no effect on the period or on the mode.
- R3: In disabled mode, `rst_req_o` and `win_open_o` stay low whatever happens on the tick and refresh inputs.
- R4: In default mode the period is DEF_TICKS ticks, which is 150 by default.
- R5: In programmed mode the period is (period_code + 1) × STEP_TICKS ticks, with STEP_TICKS = 20 by default.
- R6: The closed half of a period P lasts P/2 ticks. `win_open_o` goes high in the cycle after the tick that completes the closed half, and it is low during the closed half.
- R7: A refresh while `win_open_o` is high starts a new period without a reset request. `win_open_o` is low in the next cycle.
- R8: A refresh while the window is closed (and the block is enabled) makes `rst_req_o` high for exactly the next cycle and starts a new period.
- R9: If the period's last tick arrives with no refresh, `rst_req_o` is high for exactly the next cycle, `win_open_o` drops, and a new period starts.
- R10: When a refresh and a tick arrive in the same cycle, the refresh is handled and the tick is dropped.
- R11: While `rst_n` is low, `rst_req_o` and `win_open_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per millisecond |
| refresh_i | input | 1 | One-cycle refresh strobe from the host |
| cfg_strap | input | 2 | Configuration strap: 00 disabled, 01 default, 1x programmed |
| period_code | input | CODE_W (4) | Period code used in programmed mode |
| rst_req_o | output | 1 | One-cycle reset request |
| win_open_o | output | 1 | High while a refresh is allowed |

## Verification
The assertions check on every cycle:
- Disabled mode never produces an output.
- Every reset request follows a tick or a refresh.
- A closed-half refresh is always followed by a request, and an open-half refresh never is.
- The window only opens after a tick.
- The captured mode never changes after capture.

Only the directed scenarios can show that the counts are exact. They show that the window opens on tick P/2 and that the timeout lands on tick P for both the default and the programmed period. They also show that late strap and code changes are ignored, and that refresh wins over a coincident tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WD_OFF     = 2'd0,
        WD_DEFAULT = 2'd1,
        WD_PROG    = 2'd2
    } wd_mode_e;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_CLOSED = 2'd2,
        ST_OPEN   = 2'd3
    } wd_state_e;

    // Strap decode: 00 off, 01 fixed default, 1x programmed code
    function automatic wd_mode_e decode_strap(input logic [1:0] strap);
        wd_mode_e m;
        unique case (strap)
            2'b00:   m = WD_OFF;
            2'b01:   m = WD_DEFAULT;
            default: m = WD_PROG;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wdog_period_sel.sv
module wdog_period_sel
    import wdog_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int STEP_TICKS = 20,
    parameter int DEF_TICKS  = 150,
    parameter int CNT_W      = 9
) (
    input  wd_mode_e            mode,
    input  logic [CODE_W-1:0]   code,
    output logic [CNT_W-1:0]    period,
    output logic [CNT_W-1:0]    half
);

    localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEF_TICKS);

    logic [CNT_W-1:0] prog_p;

    always_comb begin
        prog_p = CNT_W'((int'(code) + 1) * STEP_TICKS);
        unique case (mode)
            WD_PROG:    period = prog_p;
            WD_DEFAULT: period = DEF_P;
            default:    period = DEF_P;
        endcase
        half = period >> 1;
    end

endmodule

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);

    assign cnt_nxt = cnt + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_mode_e         mode_sel,
    input  logic             tick,
    input  logic             refresh,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] half,
    input  logic [CNT_W-1:0] period,
    output wd_state_e        state,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             win_open,
    output logic             rst_req
);

    wd_state_e state_nxt;
    logic      fault;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_INIT;
            rst_req <= 1'b0;
        end else begin
            state   <= state_nxt;
            rst_req <= fault;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nxt = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        fault     = 1'b0;
        unique case (state)
            ST_INIT: begin
                cnt_clr   = 1'b1;
                state_nxt = (mode_sel == WD_OFF) ? ST_IDLE : ST_CLOSED;
            end
            ST_IDLE: begin
                state_nxt = ST_IDLE;
            end
            ST_CLOSED: begin
                if (refresh) begin
                    fault   = 1'b1;
                    cnt_clr = 1'b1;
                end else if (tick) begin
                    cnt_inc = 1'b1;
                    if (cnt_nxt == half) begin
                        state_nxt = ST_OPEN;
                    end
                end
            end
            ST_OPEN: begin
                if (refresh) begin
                    cnt_clr   = 1'b1;
                    state_nxt = ST_CLOSED;
                end else if (tick) begin
                    if (cnt_nxt == period) begin
                        fault     = 1'b1;
                        cnt_clr   = 1'b1;
                        state_nxt = ST_CLOSED;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: state_nxt = ST_INIT;
        endcase
        win_open = (state == ST_OPEN);
    end

endmodule

// File: rtl/win_wdog.sv
module win_wdog
    import wdog_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int STEP_TICKS = 20,
    parameter int DEF_TICKS  = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              refresh_i,
    input  logic [1:0]        cfg_strap,
    input  logic [CODE_W-1:0] period_code,
    output logic              rst_req_o,
    output logic              win_open_o
);

    localparam int PROG_MAX = (2 ** CODE_W) * STEP_TICKS;
    localparam int MAX_P    = (PROG_MAX > DEF_TICKS) ? PROG_MAX : DEF_TICKS;
    localparam int CNT_W    = $clog2(MAX_P + 1);

    wd_state_e         st;
    wd_mode_e          mode_q;
    wd_mode_e          mode_live;
    wd_mode_e          mode_sel;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  period;
    logic [CNT_W-1:0]  half;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              cnt_clr;
    logic              cnt_inc;

    assign mode_live = decode_strap(cfg_strap);
    assign mode_sel  = (st == ST_INIT) ? mode_live : mode_q;

    // Configuration captured once, on the edge that leaves ST_INIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= WD_OFF;
            code_q <= '0;
        end else if (st == ST_INIT) begin
            mode_q <= mode_live;
            code_q <= period_code;
        end
    end

    wdog_period_sel #(
        .CODE_W     (CODE_W),
        .STEP_TICKS (STEP_TICKS),
        .DEF_TICKS  (DEF_TICKS),
        .CNT_W      (CNT_W)
    ) u_psel (
        .mode   (mode_q),
        .code   (code_q),
        .period (period),
        .half   (half)
    );

    wdog_tick_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .cnt     (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    wdog_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .tick     (tick_i),
        .refresh  (refresh_i),
        .cnt_nxt  (cnt_nxt),
        .half     (half),
        .period   (period),
        .state    (st),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .win_open (win_open_o),
        .rst_req  (rst_req_o)
    );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             refresh_i,
    input logic             rst_req_o,
    input logic             win_open_o,
    input wd_mode_e         mode_q,
    input wd_state_e        st,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] period
);

    // R3
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == WD_OFF) |-> (!rst_req_o && !win_open_o));

    // R2
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_INIT && $past(st) != ST_INIT) |-> $stable(mode_q));

    // R8
    early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLOSED && refresh_i) |=> rst_req_o);

    // R7
    good_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPEN && refresh_i) |=> (!rst_req_o && !win_open_o));

    // R9
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(refresh_i || tick_i));

    // R6
    open_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open_o) |-> $past(tick_i && !refresh_i));

    // R4 R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLOSED || st == ST_OPEN) |-> (cnt_q < period));

endmodule

bind win_wdog wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .refresh_i  (refresh_i),
    .rst_req_o  (rst_req_o),
    .win_open_o (win_open_o),
    .mode_q     (mode_q),
    .st         (st),
    .cnt_q      (cnt_q),
    .period     (period)
);

// File: tb/win_wdog_bench.sv
module win_wdog_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i;
    logic       refresh_i;
    logic [1:0] cfg_strap;
    logic [3:0] period_code;
    logic       rst_req_o;
    logic       win_open_o;

    int vecs = 0;
    int bad  = 0;

    always #4 clk = ~clk;

    win_wdog u_win_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .refresh_i   (refresh_i),
        .cfg_strap   (cfg_strap),
        .period_code (period_code),
        .rst_req_o   (rst_req_o),
        .win_open_o  (win_open_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit t, input bit r);
        tick_i    = t;
        refresh_i = r;
        @(negedge clk);
        tick_i    = 1'b0;
        refresh_i = 1'b0;
    endtask

    task automatic run_ticks(input int n, output int reqs, output int opens);
        reqs  = 0;
        opens = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0);
            reqs  += int'(rst_req_o);
            opens += int'(win_open_o);
        end
    endtask

    task automatic do_reset(input logic [1:0] strap, input logic [3:0] code);
        rst_n       = 1'b0;
        cfg_strap   = strap;
        period_code = code;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0;
        tick_i = 1'b1;
        refresh_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 rst_req in reset", int'(rst_req_o), 0);
        chk("R11 win_open in reset", int'(win_open_o), 0);
        tick_i = 1'b0;
        refresh_i = 1'b0;
    endtask

    task automatic t_window_default;
        int r, o;
        do_reset(2'b01, 4'd0);
        run_ticks(74, r, o);
        chk("R6 closed before half", o, 0);
        chk("R6 no req in closed", r, 0);
        run_ticks(1, r, o);
        chk("R4 R6 opens at tick 75", int'(win_open_o), 1);
        step(1'b0, 1'b1);
        chk("R7 no req on good refresh", int'(rst_req_o), 0);
        chk("R7 window closes", int'(win_open_o), 0);
        run_ticks(74, r, o);
        chk("R7 restarted closed half", o + r, 0);
        run_ticks(1, r, o);
        chk("R7 reopens after 75", int'(win_open_o), 1);
    endtask

    task automatic t_timeout_default;
        int r, o;
        do_reset(2'b01, 4'd9);
        run_ticks(149, r, o);
        chk("R9 no req before 150", r, 0);
        run_ticks(1, r, o);
        chk("R4 R9 req at tick 150", int'(rst_req_o), 1);
        chk("R9 window drops", int'(win_open_o), 0);
        step(1'b0, 1'b0);
        chk("R9 req one cycle", int'(rst_req_o), 0);
        run_ticks(74, r, o);
        chk("R9 new period closed", o + r, 0);
        run_ticks(1, r, o);
        chk("R9 new period opens", int'(win_open_o), 1);
    endtask

    task automatic t_early;
        int r, o;
        do_reset(2'b01, 4'd0);
        run_ticks(10, r, o);
        step(1'b0, 1'b1);
        chk("R8 early refresh req", int'(rst_req_o), 1);
        step(1'b0, 1'b0);
        chk("R8 req one cycle", int'(rst_req_o), 0);
        run_ticks(74, r, o);
        chk("R8 restart closed", o + r, 0);
        run_ticks(1, r, o);
        chk("R8 restart opens at 75", int'(win_open_o), 1);
    endtask

    task automatic t_disabled;
        int r = 0;
        int o = 0;
        do_reset(2'b00, 4'd0);
        for (int i = 0; i < 400; i++) begin
            step(1'b1, (i % 7) == 0);
            r += int'(rst_req_o);
            o += int'(win_open_o);
        end
        chk("R1 R3 disabled no req", r, 0);
        chk("R3 disabled never open", o, 0);
    endtask

    task automatic t_programmed;
        int r, o;
        do_reset(2'b10, 4'd3);
        run_ticks(39, r, o);
        chk("R5 code3 closed 39", o, 0);
        run_ticks(1, r, o);
        chk("R5 code3 opens at 40", int'(win_open_o), 1);
        run_ticks(39, r, o);
        chk("R5 code3 no req before 80", r, 0);
        run_ticks(1, r, o);
        chk("R5 code3 req at 80", int'(rst_req_o), 1);
        do_reset(2'b11, 4'd0);
        run_ticks(19, r, o);
        chk("R1 R5 strap11 code0 no req 19", r, 0);
        run_ticks(1, r, o);
        chk("R1 R5 strap11 code0 req at 20", int'(rst_req_o), 1);
    endtask

    task automatic t_ignored;
        int r, o;
        do_reset(2'b10, 4'd0);
        cfg_strap   = 2'b00;
        period_code = 4'd15;
        run_ticks(19, r, o);
        chk("R2 late change no req 19", r, 0);
        run_ticks(1, r, o);
        chk("R2 late change still 20", int'(rst_req_o), 1);
        do_reset(2'b00, 4'd0);
        cfg_strap = 2'b01;
        run_ticks(400, r, o);
        chk("R2 stays disabled", r + o, 0);
    endtask

    task automatic t_priority;
        int r, o;
        do_reset(2'b01, 4'd0);
        run_ticks(74, r, o);
        step(1'b1, 1'b1);
        chk("R10 refresh wins in closed", int'(rst_req_o), 1);
        chk("R10 tick dropped", int'(win_open_o), 0);
        do_reset(2'b01, 4'd0);
        run_ticks(149, r, o);
        step(1'b1, 1'b1);
        chk("R10 refresh wins at end", int'(rst_req_o), 0);
        chk("R10 closes after refresh", int'(win_open_o), 0);
    endtask

    initial begin
        tick_i = 1'b0;
        refresh_i = 1'b0;
        cfg_strap = 2'b01;
        period_code = 4'd0;
        rst_n = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_window_default();
        t_timeout_default();
        t_early();
        t_disabled();
        t_programmed();
        t_ignored();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vecs++;
        bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule